// File: doc/BRIEF.md
# Three-wire serial EEPROM slave model

This block is a synthesizable model of a small serial EEPROM organised as 64 words of 16 bits. A host drives a select line, a serial clock and a serial data input; the block answers on a serial data output with a separate output-enable for a tri-state pad. A program-enable pin adds a hardware lock on all commands that change state. The block runs from a fast system clock. All serial pins pass through a synchronizer and serial-clock edges are found by sampling.

Each frame begins with a 1 start bit, followed by a two-bit command code and a six-bit word address. Reads stream data back without a break. Single-word writes, four-word page writes and a fill-all command load a staging buffer. That buffer is committed when select drops. A self-timed programming interval of a set number of system clocks follows the commit. While the interval runs and select is high, the output pin reports busy or ready.

Top module: `mw_eeprom_slave`

## Requirements
- R1: Frame bits are taken on rising serial-clock edges while select is high. Zeros ahead of the first 1 are skipped. That 1 is the start bit, and after it come a two-bit code and six address bits, most significant bit first.
- R2: Code 10 is a read. On the edge that takes the last address bit, the output is enabled and drives a 0 dummy bit. Each following rising edge drives the next data bit, most significant bit first.
- R3: When clocking continues past 16 read bits, the next word follows with no gap. The address advances by one per word and wraps from 63 to 0.
- R4: After reset every word reads 16'hFFFF and writes are locked. While locked, write (01), page write (11) and fill-all are dropped and no programming interval starts.
- R5: Code 00 uses address bits [5:4] as a sub-command. 11 unlocks writes, 00 locks them again, and 01 is fill-all. Reads work whether writes are locked or unlocked.
- R6: Code 01 takes 16 data bits for the addressed word. The word is stored when select falls after the last data bit.
- R7: Code 11 takes a stream of words. Address bits [1:0] advance after each word and wrap from 3 to 0, while bits [5:2] stay fixed, so a fifth word replaces the first. Only complete words are stored.
- R8: Fill-all stores its 16-bit value into all 64 words.
- R9: A commit starts a busy interval of PROG_CYCLES system clocks. With select high, the output is enabled and drives 0 while busy and 1 once ready. With select low, the output is disabled.
- R10: The ready level stays on the output until the start bit of the next frame. The output enable then drops unless a read follows.
- R11: While the busy interval runs, start bits are ignored, so no frame sent during it has any effect.
- R12: If select falls before the first complete data word of a write-type frame, the frame is dropped and nothing is stored.
- R13: With program-enable low, write, page write, fill-all, unlock and lock are all without effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_i | input | 1 | Select; high frames a command |
| sclk_i | input | 1 | Serial clock from the host |
| sdin_i | input | 1 | Serial data into the block |
| prog_en_i | input | 1 | Program-enable lock; low blocks every state-changing command |
| sdout_o | output | 1 | Serial data out: read bits or busy/ready level |
| sdout_oe_o | output | 1 | Output enable for the tri-state data pad |

## Verification
A host may send a fresh frame while the self-timed interval is still counting, which puts the frame decoder and the programming timer in play in the same cycles. The bench provokes this by writing one word, raising select again at once and shifting in a complete write to a second address while busy. It then judges the outcome by reading back: the first address holds its data and the second still reads erased. A second overlap is the ready level meeting the next start bit on the same serial edge; the bench checks that the enable is still high just before that bit and low just after it.

// File: rtl/mwe_pkg.sv
package mwe_pkg;

    typedef enum logic [2:0] {
        FS_IDLE,
        FS_OPC,
        FS_ADR,
        FS_DAT,
        FS_RD,
        FS_HOLD
    } fstate_e;

    typedef enum logic [1:0] {
        OP_SYS = 2'b00,
        OP_WR  = 2'b01,
        OP_RD  = 2'b10,
        OP_PG  = 2'b11
    } opcode_e;

    localparam logic [1:0] SUB_UNLOCK = 2'b11;
    localparam logic [1:0] SUB_LOCK   = 2'b00;
    localparam logic [1:0] SUB_FILL   = 2'b01;

endpackage

// File: rtl/mwe_insync.sv
module mwe_insync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] lvl_o
);

    logic [STAGES-1:0][W-1:0] ch_d, ch_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_comb ch_d[s] = raw_i;
            end else begin : g_next
                always_comb ch_d[s] = ch_q[s-1];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ch_q <= '0;
        else        ch_q <= ch_d;
    end

    assign lvl_o = ch_q[STAGES-1];

endmodule

// File: rtl/mwe_frame.sv
module mwe_frame import mwe_pkg::*; #(
    parameter int AW = 6,
    parameter int DW = 16,
    parameter int PW = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sel_s,
    input  logic                   sel_fall,
    input  logic                   sclk_rise,
    input  logic                   din_s,
    input  logic                   pe_s,
    input  logic                   busy_i,
    input  logic [DW-1:0]          rdata_i,
    output logic [AW-1:0]          raddr_o,
    output logic                   commit_o,
    output logic                   all_o,
    output logic [AW-$clog2(PW)-1:0] cblk_o,
    output logic [PW-1:0][DW-1:0]  cbuf_o,
    output logic [PW-1:0]          cval_o,
    output logic                   wen_o,
    output logic                   idle_o,
    output logic                   dout_o,
    output logic                   oe_o
);

    localparam int PL    = $clog2(PW);
    localparam int CNT_W = $clog2(DW + AW);
    localparam logic [CNT_W-1:0] CNT_OLAST = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_ALAST = CNT_W'(AW - 1);
    localparam logic [CNT_W-1:0] CNT_DLAST = CNT_W'(DW - 1);

    typedef struct packed {
        fstate_e               st;
        logic [CNT_W-1:0]      cnt;
        logic [1:0]            opc;
        logic [AW-1:0]         addr;
        logic [DW-1:0]         sh;
        logic [PW-1:0][DW-1:0] pbuf;
        logic [PW-1:0]         pval;
        logic [PL-1:0]         ptr;
        logic                  multi;
        logic                  all;
        logic                  done;
        logic                  wen;
        logic                  status;
        logic                  rbit;
        logic                  dout;
        logic                  oe;
    } fr_t;

    fr_t d, q;
    logic          commit;
    logic [DW-1:0] word;
    logic [AW-1:0] afull;
    int            ridx;

    always_comb begin
        d      = q;
        commit = 1'b0;
        word   = {q.sh[DW-2:0], din_s};
        afull  = {q.addr[AW-2:0], din_s};
        ridx   = DW - 1 - int'(q.cnt);

        if (!sel_s) begin
            if (sel_fall && q.done && q.wen && pe_s && !busy_i) begin
                commit   = 1'b1;
                d.status = 1'b1;
            end
            d.st   = FS_IDLE;
            d.cnt  = '0;
            d.done = 1'b0;
            d.pval = '0;
        end else if (sclk_rise) begin
            case (q.st)
                FS_IDLE: begin
                    if (din_s && !busy_i) begin
                        d.st     = FS_OPC;
                        d.cnt    = '0;
                        d.opc    = '0;
                        d.multi  = 1'b0;
                        d.all    = 1'b0;
                        d.done   = 1'b0;
                        d.pval   = '0;
                        d.status = 1'b0;
                    end
                end
                FS_OPC: begin
                    d.opc = {q.opc[0], din_s};
                    d.cnt = q.cnt + CNT_W'(1);
                    if (q.cnt == CNT_OLAST) begin
                        d.st  = FS_ADR;
                        d.cnt = '0;
                    end
                end
                FS_ADR: begin
                    d.addr = afull;
                    d.cnt  = q.cnt + CNT_W'(1);
                    if (q.cnt == CNT_ALAST) begin
                        d.cnt = '0;
                        case (opcode_e'(q.opc))
                            OP_RD: begin
                                d.st   = FS_RD;
                                d.rbit = 1'b0;
                            end
                            OP_WR: begin
                                d.st    = FS_DAT;
                                d.ptr   = afull[PL-1:0];
                                d.multi = 1'b0;
                            end
                            OP_PG: begin
                                d.st    = FS_DAT;
                                d.ptr   = afull[PL-1:0];
                                d.multi = 1'b1;
                            end
                            default: begin
                                d.st = FS_HOLD;
                                if (afull[AW-1:AW-2] == SUB_UNLOCK) begin
                                    if (pe_s) d.wen = 1'b1;
                                end else if (afull[AW-1:AW-2] == SUB_LOCK) begin
                                    if (pe_s) d.wen = 1'b0;
                                end else if (afull[AW-1:AW-2] == SUB_FILL) begin
                                    d.st  = FS_DAT;
                                    d.ptr = '0;
                                    d.all = 1'b1;
                                end
                            end
                        endcase
                    end
                end
                FS_DAT: begin
                    d.sh  = word;
                    d.cnt = q.cnt + CNT_W'(1);
                    if (q.cnt == CNT_DLAST) begin
                        d.cnt         = '0;
                        d.pbuf[q.ptr] = word;
                        d.pval[q.ptr] = 1'b1;
                        d.done        = 1'b1;
                        if (q.multi) d.ptr = q.ptr + PL'(1);
                        else         d.st  = FS_HOLD;
                    end
                end
                FS_RD: begin
                    d.rbit = rdata_i[ridx];
                    d.cnt  = q.cnt + CNT_W'(1);
                    if (q.cnt == CNT_DLAST) begin
                        d.cnt  = '0;
                        d.addr = q.addr + AW'(1);
                    end
                end
                default: ;
            endcase
        end

        d.oe   = sel_s && (d.st == FS_RD || d.status);
        d.dout = (d.st == FS_RD) ? d.rbit : !busy_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= FS_IDLE;
        end else begin
            q <= d;
        end
    end

    assign raddr_o  = q.addr;
    assign commit_o = commit;
    assign all_o    = q.all;
    assign cblk_o   = q.addr[AW-1:PL];
    assign cbuf_o   = q.pbuf;
    assign cval_o   = q.pval;
    assign wen_o    = q.wen;
    assign idle_o   = (q.st == FS_IDLE);
    assign dout_o   = q.dout;
    assign oe_o     = q.oe;

endmodule

// File: rtl/mwe_store.sv
module mwe_store #(
    parameter int AW          = 6,
    parameter int DW          = 16,
    parameter int PW          = 4,
    parameter int PROG_CYCLES = 40
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [AW-1:0]            raddr_i,
    output logic [DW-1:0]            rdata_o,
    input  logic                     commit_i,
    input  logic                     all_i,
    input  logic [AW-$clog2(PW)-1:0] cblk_i,
    input  logic [PW-1:0][DW-1:0]    cbuf_i,
    input  logic [PW-1:0]            cval_i,
    output logic                     busy_o
);

    localparam int DEPTH = 1 << AW;
    localparam int PL    = $clog2(PW);
    localparam int TW    = $clog2(PROG_CYCLES + 1);

    logic [DW-1:0] mem_d [DEPTH];
    logic [DW-1:0] mem_q [DEPTH];
    logic [TW-1:0] tmr_d, tmr_q;
    logic [AW-1:0] widx;

    always_comb begin
        mem_d = mem_q;
        widx  = '0;
        tmr_d = (tmr_q != '0) ? tmr_q - TW'(1) : '0;
        if (commit_i) begin
            tmr_d = TW'(PROG_CYCLES);
            if (all_i) begin
                for (int i = 0; i < DEPTH; i++) mem_d[i] = cbuf_i[0];
            end else begin
                for (int p = 0; p < PW; p++) begin
                    widx = {cblk_i, PL'(p)};
                    if (cval_i[p]) mem_d[widx] = cbuf_i[p];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
            tmr_q <= '0;
        end else begin
            mem_q <= mem_d;
            tmr_q <= tmr_d;
        end
    end

    assign rdata_o = mem_q[raddr_i];
    assign busy_o  = (tmr_q != '0);

endmodule

// File: rtl/mw_eeprom_slave.sv
module mw_eeprom_slave #(
    parameter int AW          = 6,
    parameter int DW          = 16,
    parameter int PAGE_WORDS  = 4,
    parameter int PROG_CYCLES = 40,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_i,
    input  logic sclk_i,
    input  logic sdin_i,
    input  logic prog_en_i,
    output logic sdout_o,
    output logic sdout_oe_o
);

    localparam int PL = $clog2(PAGE_WORDS);

    logic [3:0] lines_s;
    logic sel_s, sclk_s, din_s, pe_s;
    logic sel_fall, sclk_rise;

    typedef struct packed {
        logic sel_prev;
        logic sclk_prev;
    } edge_t;
    edge_t eg_d, eg_q;

    logic [AW-1:0]                 raddr;
    logic [DW-1:0]                 rdata;
    logic                          commit, fill_all, busy, wen, fr_idle;
    logic [AW-PL-1:0]              cblk;
    logic [PAGE_WORDS-1:0][DW-1:0] cbuf;
    logic [PAGE_WORDS-1:0]         cval;

    mwe_insync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw_i ({prog_en_i, sdin_i, sclk_i, sel_i}),
        .lvl_o (lines_s)
    );

    assign sel_s  = lines_s[0];
    assign sclk_s = lines_s[1];
    assign din_s  = lines_s[2];
    assign pe_s   = lines_s[3];

    always_comb begin
        eg_d.sel_prev  = sel_s;
        eg_d.sclk_prev = sclk_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eg_q <= '0;
        else        eg_q <= eg_d;
    end

    assign sel_fall  = eg_q.sel_prev & ~sel_s;
    assign sclk_rise = sclk_s & ~eg_q.sclk_prev;

    mwe_frame #(.AW(AW), .DW(DW), .PW(PAGE_WORDS)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_s     (sel_s),
        .sel_fall  (sel_fall),
        .sclk_rise (sclk_rise),
        .din_s     (din_s),
        .pe_s      (pe_s),
        .busy_i    (busy),
        .rdata_i   (rdata),
        .raddr_o   (raddr),
        .commit_o  (commit),
        .all_o     (fill_all),
        .cblk_o    (cblk),
        .cbuf_o    (cbuf),
        .cval_o    (cval),
        .wen_o     (wen),
        .idle_o    (fr_idle),
        .dout_o    (sdout_o),
        .oe_o      (sdout_oe_o)
    );

    mwe_store #(.AW(AW), .DW(DW), .PW(PAGE_WORDS), .PROG_CYCLES(PROG_CYCLES)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .raddr_i  (raddr),
        .rdata_o  (rdata),
        .commit_i (commit),
        .all_i    (fill_all),
        .cblk_i   (cblk),
        .cbuf_i   (cbuf),
        .cval_i   (cval),
        .busy_o   (busy)
    );

endmodule

// File: rtl/mwe_chk.sv
module mwe_chk #(
    parameter int PROG_CYCLES = 40
) (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic wen,
    input logic sel_s,
    input logic pe_s,
    input logic oe,
    input logic idle,
    input logic commit
);

    int run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run_q <= 0;
        else if (busy) run_q <= run_q + 1;
        else           run_q <= 0;
    end

    // R4
    locked_no_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wen));

    // R13
    lock_pin_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wen) |-> $past(pe_s));

    // R11
    busy_frame_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> idle);

    // R11
    no_commit_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> !busy);

    // R9
    pad_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_s |=> !oe);

    // R9
    prog_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_q < PROG_CYCLES));

endmodule

bind mw_eeprom_slave mwe_chk #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .busy   (busy),
    .wen    (wen),
    .sel_s  (sel_s),
    .pe_s   (pe_s),
    .oe     (sdout_oe_o),
    .idle   (fr_idle),
    .commit (commit)
);

// File: tb/mw_eeprom_slave_test.sv
module mw_eeprom_slave_test;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;
    localparam int PROG       = 600;
    localparam int WDOG       = 190000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel = 1'b0, sclk = 1'b0, sdin = 1'b0, pe = 1'b1;
    logic sdout, sdoe;

    int nchk = 0, nfail = 0, cyc = 0;
    bit fin = 0;
    logic [15:0] em [64];
    logic [15:0] rbuf [8];
    logic [15:0] pw [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    mw_eeprom_slave #(.PROG_CYCLES(PROG)) uut (
        .clk(clk), .rst_n(rst_n), .sel_i(sel), .sclk_i(sclk),
        .sdin_i(sdin), .prog_en_i(pe), .sdout_o(sdout), .sdout_oe_o(sdoe)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == WDOG && !fin) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog actual=%0d expected<%0d", cyc, WDOG);
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic sbit(input logic b, output logic smp);
        sdin = b;
        tick(HALF);
        sclk = 1'b1;
        tick(HALF);
        sclk = 1'b0;
        tick(HALF);
        smp = sdout;
    endtask

    task automatic send(input logic [31:0] v, input int n, output logic last);
        for (int i = n - 1; i >= 0; i--) sbit(v[i], last);
    endtask

    task automatic sel_up();
        sel = 1'b1;
        tick(HALF);
    endtask

    task automatic sel_dn();
        sel = 1'b0;
        tick(2 * HALF);
    endtask

    task automatic hdr(input logic [1:0] op, input logic [5:0] a, output logic last);
        logic s;
        sbit(1'b1, s);
        send({30'd0, op}, 2, s);
        send({26'd0, a}, 6, last);
    endtask

    task automatic wr_word(input logic [5:0] a, input logic [15:0] dv);
        logic s;
        sel_up();
        hdr(2'b01, a, s);
        send({16'd0, dv}, 16, s);
        sel_dn();
    endtask

    // leaves select high with the ready level showing
    task automatic await_ready(input string tag, input bit strict);
        int n = 0;
        sel_up();
        if (strict) chk({tag, " busy level"}, {30'd0, sdoe, sdout}, 32'h2);
        while (!(sdoe === 1'b1 && sdout === 1'b1) && n < PROG + 100) begin
            tick(1);
            n++;
        end
        chk({tag, " ready"}, {30'd0, sdoe, sdout}, 32'h3);
        if (strict) chk({tag, " interval bound"}, {31'd0, n < PROG}, 32'h1);
    endtask

    task automatic do_write(input logic [5:0] a, input logic [15:0] dv, input string tag);
        wr_word(a, dv);
        await_ready(tag, 1'b0);
        sel_dn();
        em[a] = dv;
    endtask

    task automatic do_page(input logic [5:0] a, input int n, input string tag);
        logic s;
        sel_up();
        hdr(2'b11, a, s);
        for (int i = 0; i < n; i++) send({16'd0, pw[i]}, 16, s);
        sel_dn();
        await_ready(tag, 1'b0);
        sel_dn();
        for (int i = 0; i < n; i++) em[{a[5:2], 2'(a[1:0] + 2'(i))}] = pw[i];
    endtask

    task automatic sys_cmd(input logic [1:0] sub);
        logic s;
        sel_up();
        hdr(2'b00, {sub, 4'b0000}, s);
        sel_dn();
    endtask

    task automatic rd(input logic [5:0] a, input int n, input int zeros);
        logic s;
        logic [15:0] v;
        sel_up();
        for (int z = 0; z < zeros; z++) sbit(1'b0, s);
        hdr(2'b10, a, s);
        chk("R2 dummy bit with enable", {30'd0, sdoe, s}, 32'h2);
        for (int w = 0; w < n; w++) begin
            v = '0;
            for (int i = 0; i < 16; i++) begin
                sbit(1'b0, s);
                v = {v[14:0], s};
            end
            rbuf[w] = v;
        end
        sel_dn();
    endtask

    task automatic no_status(input string tag);
        sel_up();
        chk(tag, {31'd0, sdoe}, 32'h0);
        sel_dn();
    endtask

    initial begin
        logic s;
        int unused_seed;
        unused_seed = $urandom(32'h5eed);
        for (int i = 0; i < 64; i++) em[i] = 16'hFFFF;

        tick(5);
        chk("R9 enable off in reset", {31'd0, sdoe}, 32'h0);
        rst_n = 1'b1;
        tick(5);
        no_status("R9 no status after reset");

        // locked after reset
        wr_word(6'd5, 16'h0F0F);
        no_status("R4 locked write starts no interval");
        rd(6'd5, 1, 0);
        chk("R4 erased word kept while locked", rbuf[0], 32'hFFFF);

        // unlock, timed write
        sys_cmd(2'b11);
        wr_word(6'd5, 16'hA5C3);
        em[5] = 16'hA5C3;
        await_ready("R9", 1'b1);
        tick(20);
        chk("R10 ready level held", {30'd0, sdoe, sdout}, 32'h3);
        sbit(1'b1, s);
        chk("R10 enable drops on start bit", {31'd0, sdoe}, 32'h0);
        send(32'h0, 2, s);
        send(32'h30, 6, s);
        sel_dn();
        rd(6'd5, 1, 0);
        chk("R6 single word stored", rbuf[0], 32'hA5C3);

        // leading zeros
        rd(6'd5, 1, 3);
        chk("R1 leading zeros skipped", rbuf[0], 32'hA5C3);

        // sequential read wrap
        do_write(6'd63, 16'h1234, "R3 prep");
        do_write(6'd0, 16'h4321, "R3 prep");
        rd(6'd63, 2, 0);
        chk("R3 word at top", rbuf[0], 32'h1234);
        chk("R3 wrap to zero", rbuf[1], 32'h4321);

        // page write with wrap, six words
        for (int i = 0; i < 6; i++) pw[i] = 16'hC000 + 16'(i);
        do_page(6'h12, 6, "R7 six words");
        rd(6'h0F, 6, 0);
        chk("R7 below page untouched", rbuf[0], 32'hFFFF);
        chk("R7 slot0 third word", rbuf[1], 32'hC002);
        chk("R7 slot1 fourth word", rbuf[2], 32'hC003);
        chk("R7 fifth replaces first", rbuf[3], 32'hC004);
        chk("R7 sixth replaces second", rbuf[4], 32'hC005);
        chk("R7 above page untouched", rbuf[5], 32'hFFFF);

        // page with trailing partial word
        sel_up();
        hdr(2'b11, 6'h20, s);
        send(32'h1357, 16, s);
        send(32'hA5, 8, s);
        sel_dn();
        await_ready("R7 partial", 1'b0);
        sel_dn();
        em[6'h20] = 16'h1357;
        rd(6'h20, 2, 0);
        chk("R7 complete word stored", rbuf[0], 32'h1357);
        chk("R7 partial word dropped", rbuf[1], 32'hFFFF);

        // abort
        sel_up();
        hdr(2'b01, 6'd7, s);
        send(32'hAB, 8, s);
        sel_dn();
        no_status("R12 abort starts no interval");
        rd(6'd7, 1, 0);
        chk("R12 aborted word unchanged", rbuf[0], 32'hFFFF);

        // frame during busy
        wr_word(6'd9, 16'h1111);
        em[9] = 16'h1111;
        sel_up();
        hdr(2'b01, 6'd10, s);
        send(32'h2222, 16, s);
        sel_dn();
        await_ready("R11", 1'b0);
        sel_dn();
        rd(6'd9, 2, 0);
        chk("R11 first write kept", rbuf[0], 32'h1111);
        chk("R11 write during busy ignored", rbuf[1], 32'hFFFF);

        // lock command
        sys_cmd(2'b00);
        wr_word(6'd11, 16'h7777);
        no_status("R5 lock blocks write");
        rd(6'd11, 1, 0);
        chk("R5 read works while locked", rbuf[0], 32'hFFFF);
        sys_cmd(2'b11);

        // program-enable pin
        pe = 1'b0;
        tick(4);
        wr_word(6'd20, 16'hBEEF);
        no_status("R13 pin low blocks write");
        sys_cmd(2'b00);
        pe = 1'b1;
        tick(4);
        do_write(6'd21, 16'hCAFE, "R13 lock blocked by pin");
        rd(6'd20, 2, 0);
        chk("R13 blocked word unchanged", rbuf[0], 32'hFFFF);
        chk("R13 still unlocked", rbuf[1], 32'hCAFE);

        // fill all
        sel_up();
        hdr(2'b00, 6'b010000, s);
        send(32'h5A5A, 16, s);
        sel_dn();
        await_ready("R8", 1'b0);
        sel_dn();
        for (int i = 0; i < 64; i++) em[i] = 16'h5A5A;
        rd(6'd62, 3, 0);
        chk("R8 word 62", rbuf[0], 32'h5A5A);
        chk("R8 word 63", rbuf[1], 32'h5A5A);
        chk("R8 word 0", rbuf[2], 32'h5A5A);

        // random mix against the model
        for (int k = 0; k < 12; k++) begin
            int op;
            logic [5:0] a;
            op = int'($urandom % 3);
            a  = 6'($urandom);
            if (op == 0) begin
                do_write(a, 16'($urandom), "R6 random");
            end else if (op == 1) begin
                int n;
                n = 1 + int'($urandom % 6);
                for (int i = 0; i < n; i++) pw[i] = 16'($urandom);
                do_page(a, n, "R7 random");
            end
            rd(a, 2, 0);
            chk("R6 random word", rbuf[0], {16'd0, em[a]});
            chk("R3 random next word", rbuf[1], {16'd0, em[6'(a + 6'd1)]});
        end

        fin = 1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule